// File: doc/BRIEF.md
# Inter-Processor Command Dispatcher

A processor sends work to a peer processor by writing one command word into this block. The word names a command type, a target processor and a vector. The block checks the word and turns it into exactly one request line towards the processor complex. There are four request lines: post an interrupt, reset, halt, and resume. A halted processor must not be woken by interrupts; that behaviour belongs to the processor complex, not to this block.

Each request line stays high, with its target and vector held steady, until the complex raises `ack`. A reset command always runs in two phases. First the reset request is raised. After that request is acknowledged, a resume request to the same processor follows automatically.

The block discards two kinds of command. A command aimed at a processor number that does not exist is dropped with no trace. A reset whose vector is not the power-on-reset code is also dropped, but it raises a sticky error flag. A write that arrives while a request is still outstanding is refused, and the block reports it on a busy pulse.

Top module: `ipc_dispatch`

## Requirements
- R1: The command word carries the type in bits 17:16, the target processor in bits 12:8 and the vector in bits 5:0. All other bits are ignored. An accepted write shows on the outputs in the cycle after the write.
- R2: Type 0 raises `post_int`, with `tgt_cpu` and `tgt_vec` taken from the word.
- R3: Type 1 with vector equal to `POR_CODE` (default 0x01) raises `post_rst`. In the cycle after that request is acknowledged, `post_resume` rises for the same processor and vector.
- R4: Type 1 with any other vector (target in range) raises no request. It sets `rst_err`, which stays set until `err_clr`. If a set and a clear happen in the same cycle, the set wins.
- R5: Type 2 raises `post_halt`.
- R6: Type 3 raises `post_resume`.
- R7: A target number at or above `NCPU` (default 4) raises no request and leaves `rst_err` unchanged, whatever the type.
- R8: A raised request, together with `tgt_cpu` and `tgt_vec`, holds steady while `ack` is low. It drops in the cycle after `ack` (except for the reset-to-resume step in R3).
- R9: A write made while any request is raised is refused and changes nothing. `cmd_busy` pulses high in the following cycle.
- R10: After reset, every request, `cmd_busy` and `rst_err` are low. At most one request line is ever high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_word | input | 32 | Command word |
| err_clr | input | 1 | Clears the sticky reset-vector error |
| ack | input | 1 | Processor complex takes the raised request |
| post_int | output | 1 | Interrupt post request |
| post_rst | output | 1 | Reset request |
| post_halt | output | 1 | Halt request |
| post_resume | output | 1 | Resume request |
| tgt_cpu | output | 5 | Target processor of the raised request |
| tgt_vec | output | 6 | Vector of the raised request |
| cmd_busy | output | 1 | One-cycle pulse: the previous write was refused |
| rst_err | output | 1 | Sticky flag: a reset with a wrong vector was dropped |

## Verification
The hardest conditions to reach are the ones that depend on a request already being raised. These are a refused write, and the automatic step from reset to resume. The bench reaches them by holding `ack` low for one cycle after every accepted command. During that cycle it writes a different word, then checks that `cmd_busy` pulses and that the raised request, target and vector are unchanged. Only after that check does it acknowledge, which for a reset brings out the resume phase.

The bench sweeps every type against targets 0 to 7 and 31, and against four vectors. This covers the range limit of R7 and the bad-vector path of R4. A separate case then sets and clears the error flag in the same cycle.

// File: rtl/ipc_dispatch.sv
module ipc_dispatch #(
  parameter int unsigned NCPU     = 4,
  parameter logic [5:0]  POR_CODE = 6'h01
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  logic [31:0] cmd_word,
  input  logic        err_clr,
  input  logic        ack,
  output logic        post_int,
  output logic        post_rst,
  output logic        post_halt,
  output logic        post_resume,
  output logic [4:0]  tgt_cpu,
  output logic [5:0]  tgt_vec,
  output logic        cmd_busy,
  output logic        rst_err
);

  typedef enum logic [2:0] {
    K_NONE, K_INT, K_RST, K_HALT, K_RES
  } kind_t;

  kind_t      pend, want;
  logic [4:0] cpu_q;
  logic [5:0] vec_q;

  logic [1:0] f_type;
  logic [4:0] f_cpu;
  logic [5:0] f_vec;
  logic       active, in_range, vec_ok, fresh, take, bad_rst;

  assign f_type   = cmd_word[17:16];
  assign f_cpu    = cmd_word[12:8];
  assign f_vec    = cmd_word[5:0];

  assign active   = (pend != K_NONE);
  assign in_range = 32'(f_cpu) < NCPU;
  assign vec_ok   = (f_type != 2'd1) || (f_vec == POR_CODE);
  assign fresh    = cmd_wr && !active && in_range;
  assign take     = fresh && vec_ok;
  assign bad_rst  = fresh && !vec_ok;

  always_comb begin
    case (f_type)
      2'd0:    want = K_INT;
      2'd1:    want = K_RST;
      2'd2:    want = K_HALT;
      default: want = K_RES;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend     <= K_NONE;
      cpu_q    <= '0;
      vec_q    <= '0;
      cmd_busy <= 1'b0;
      rst_err  <= 1'b0;
    end else begin
      cmd_busy <= cmd_wr && active;
      if (bad_rst)      rst_err <= 1'b1;
      else if (err_clr) rst_err <= 1'b0;
      if (active && ack) begin
        pend <= (pend == K_RST) ? K_RES : K_NONE;
      end else if (take) begin
        pend  <= want;
        cpu_q <= f_cpu;
        vec_q <= f_vec;
      end
    end
  end

  assign post_int    = (pend == K_INT);
  assign post_rst    = (pend == K_RST);
  assign post_halt   = (pend == K_HALT);
  assign post_resume = (pend == K_RES);
  assign tgt_cpu     = cpu_q;
  assign tgt_vec     = vec_q;

endmodule

module ipc_dispatch_chk #(
  parameter int unsigned NCPU     = 4,
  parameter logic [5:0]  POR_CODE = 6'h01
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_wr,
  input logic [31:0] cmd_word,
  input logic        err_clr,
  input logic        ack,
  input logic        post_int,
  input logic        post_rst,
  input logic        post_halt,
  input logic        post_resume,
  input logic [4:0]  tgt_cpu,
  input logic [5:0]  tgt_vec,
  input logic        cmd_busy,
  input logic        rst_err
);
  logic [3:0] reqs;
  logic       any;
  assign reqs = {post_int, post_rst, post_halt, post_resume};
  assign any  = |reqs;

  a_r10_one_req: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(reqs));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (any && !ack) |=> (reqs == $past(reqs)) && $stable(tgt_cpu) && $stable(tgt_vec));

  a_r8_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (any && ack && !post_rst) |=> !any);

  a_r3_resume_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (post_rst && ack) |=> post_resume && $stable(tgt_cpu));

  a_r9_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && any) |=> cmd_busy);

  a_r7_range: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !any && (32'(cmd_word[12:8]) >= NCPU)) |=> !any);

  a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_err && !err_clr) |=> rst_err);

  a_r4_bad_vec: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !any && (32'(cmd_word[12:8]) < NCPU) && cmd_word[17:16] == 2'd1
     && cmd_word[5:0] != POR_CODE) |=> rst_err && !any);
endmodule

bind ipc_dispatch ipc_dispatch_chk #(.NCPU(NCPU), .POR_CODE(POR_CODE)) u_chk (.*);

// File: tb/sim_ipc_dispatch.sv
module sim_ipc_dispatch;
  localparam int unsigned NCPU = 4;
  localparam logic [5:0]  POR  = 6'h01;

  logic clk = 0, rst_n = 0, cmd_wr = 0, err_clr = 0, ack = 0;
  logic [31:0] cmd_word = '0;
  logic post_int, post_rst, post_halt, post_resume, cmd_busy, rst_err;
  logic [4:0] tgt_cpu;
  logic [5:0] tgt_vec;

  int checks = 0, fails = 0;
  logic err_exp = 0;

  always #5 clk = ~clk;

  ipc_dispatch #(.NCPU(NCPU), .POR_CODE(POR)) u0 (.*);

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] word(input int t, input int c, input int v);
    return {14'h2aaa, 2'(t), 3'b101, 5'(c), 2'b11, 6'(v)};
  endfunction

  function automatic int reqs();
    return {post_int, post_rst, post_halt, post_resume};
  endfunction

  task automatic issue(input int t, input int c, input int v);
    int exp_req;
    bit ok;
    @(negedge clk); cmd_wr = 1; cmd_word = word(t, c, v);
    @(negedge clk); cmd_wr = 0;
    ok = (c < NCPU) && (t != 1 || v == POR);
    if (c < NCPU && t == 1 && v != POR) err_exp = 1;
    exp_req = ok ? (8 >> t) : 0;
    chk(reqs(), exp_req, $sformatf("R1/R2/R3/R5/R6/R7 req t=%0d c=%0d v=%0d", t, c, v));
    chk(rst_err, err_exp, "R4/R7 rst_err");
    if (ok) begin
      chk(tgt_cpu, c, "R1 tgt_cpu");
      chk(tgt_vec, v, "R1 tgt_vec");
      cmd_wr = 1; cmd_word = word((t + 1) % 4, (c + 1) % NCPU, v ^ 6'h3f);
      @(negedge clk); cmd_wr = 0;
      chk(cmd_busy, 1, "R9 busy pulse");
      chk(reqs(), exp_req, "R8/R9 held");
      chk(tgt_cpu, c, "R8/R9 cpu held");
      chk(tgt_vec, v, "R8/R9 vec held");
      ack = 1;
      @(negedge clk); ack = 0;
      chk(cmd_busy, 0, "R9 busy one cycle");
      if (t == 1) begin
        chk(reqs(), 1, "R3 resume after reset");
        chk(tgt_cpu, c, "R3 resume target");
        ack = 1;
        @(negedge clk); ack = 0;
      end
      chk(reqs(), 0, "R8 drop after ack");
    end
    if (err_exp) begin
      err_clr = 1;
      @(negedge clk); err_clr = 0;
      err_exp = 0;
      chk(rst_err, 0, "R4 clear");
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(reqs(), 0, "R10 reset reqs");
    chk(cmd_busy, 0, "R10 reset busy");
    chk(rst_err, 0, "R10 reset err");
    rst_n = 1;
    for (int t = 0; t < 4; t++)
      for (int c = 0; c < 9; c++)
        for (int vi = 0; vi < 4; vi++)
          issue(t, (c == 8) ? 31 : c, (vi == 0) ? 0 : (vi == 1) ? 1 : (vi == 2) ? 5 : 63);
    @(negedge clk); cmd_wr = 1; cmd_word = word(1, 2, 9);
    @(negedge clk); cmd_wr = 1; cmd_word = word(1, 3, 4); err_clr = 1;
    @(negedge clk); cmd_wr = 0; err_clr = 0;
    chk(rst_err, 1, "R4 set wins over clear");
    chk(reqs(), 0, "R4 no request");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R10 actual=1 expected=0");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule